// File: doc/BRIEF.md
# Manchester Telegram Transmitter

This block turns one telegram request into a serial, Manchester-coded bit stream for a two-wire bus on which power and data share the same wires. The stream drives a single control output that switches a current sink. A request arrives on a valid/ready port. It carries a frame kind and the field values, and the frame kind picks which fields are sent.

On acceptance the block builds the frame in one step. The frame holds a two-bit direction start code, the payload fields for the chosen kind, and ten parity bits. The block then shifts the frame out at a bit rate set by a selectable clock divider. After the last bit it holds the line low for an idle gap, and only then takes the next request.

Top module: `manch_tx`

## Requirements
- R1: After reset, and until the first request is accepted, `line_out` is 0, `busy` is 0 and `req_ready` is 1.
- R2: A request is accepted on a rising clock edge where both `req_valid` and `req_ready` are 1. `busy` is 1 and `req_ready` is 0 from the next cycle until the idle gap ends. A `req_valid` pulse, or a change of any request field or of `rate_code`, while `busy` is 1 has no effect on `line_out`.
- R3: Frame kinds by `req_kind`: 0 = normal (address, command); 1 = write (address, command, register, 16-bit data); 2 = read (address, command, register); 3 = result (`req_data[10:0]`); 4 = readout (register, 16-bit data). Kinds 0 to 2 send the start code 0 then 0. Kinds 3 and 4 send 0 then 1.
- R4: After the start code the fields go out in the listed order, each least significant bit first. Widths are 10 bits for address, 3 for command, 5 for register and 16 for data.
- R5: Ten parity bits P0..P9 follow the payload, in that order. Pi is the XOR of every payload bit whose index j (0 = first payload bit sent, start bits excluded) satisfies j mod 10 = i.
- R6: Each bit cell is two half cells of k clock cycles each. A 1 is sent as high then low, and a 0 as low then high. The first half cell starts in the cycle after the accepting edge.
- R7: `rate_code` is sampled at acceptance and gives k: code 0 gives 8, 1 gives 4, 2 gives 2 and 3 gives 1.
- R8: After the last parity bit, `line_out` stays 0 and `busy` stays 1 for 4k cycles (two bit periods). `req_ready` is then 1 again.
- R9: The values 5, 6 and 7 of `req_kind` produce a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 3 | Frame kind |
| req_addr | input | 10 | Device address field |
| req_cmd | input | 3 | Command field |
| req_reg | input | 5 | Register number field |
| req_data | input | 16 | Data field (result frames use the low 11 bits) |
| rate_code | input | 2 | Bit-rate divider select |
| line_out | output | 1 | Manchester-coded current-sink control |
| busy | output | 1 | Frame or idle gap in progress |

## Verification
Take the accepting edge as time zero and let N be the frame length in bits. Half cell h of bit b then occupies cycles (2b+h)k up to (2b+h+1)k-1. The idle gap covers cycles 2kN to 2kN+4k-1, and `req_ready` returns at cycle 2kN+4k. The bench counts falling edges from the accepting edge and compares `line_out` and `busy` at every falling edge against a frame it builds itself. Some frames are sent while the request fields and the rate select are scrambled during transmission, to show that these have no effect.

// File: rtl/manch_tx.sv
module manch_tx #(
  parameter int ADDR_W = 10,
  parameter int CMD_W  = 3,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16,
  parameter int RES_W  = 11,
  parameter int PAR_N  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        rate_code,
  output logic              line_out,
  output logic              busy
);
  localparam int MAXP  = ADDR_W + CMD_W + REG_W + DATA_W;
  localparam int FR_W  = 2 + MAXP + PAR_N;
  localparam int CNT_W = $clog2(FR_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} st_t;
  st_t st;

  logic [FR_W-1:0]  sh, fr;
  logic [MAXP-1:0]  pl;
  logic [CNT_W-1:0] plen, left;
  logic [PAR_N-1:0] par;
  logic [3:0]       k, kdiv, hcnt;
  logic [5:0]       gcnt;
  logic             half, dir;

  wire accept = req_valid && req_ready;
  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign line_out  = (st == S_SEND) && (sh[0] ^ half);

  always_comb begin
    case (rate_code)
      2'd0:    kdiv = 4'd8;
      2'd1:    kdiv = 4'd4;
      2'd2:    kdiv = 4'd2;
      default: kdiv = 4'd1;
    endcase
  end

  always_comb begin
    pl  = '0;
    dir = 1'b0;
    case (req_kind)
      3'd1: begin
        pl   = {req_data, req_reg, req_cmd, req_addr};
        plen = CNT_W'(MAXP);
      end
      3'd2: begin
        pl[ADDR_W+CMD_W+REG_W-1:0] = {req_reg, req_cmd, req_addr};
        plen = CNT_W'(ADDR_W + CMD_W + REG_W);
      end
      3'd3: begin
        pl[RES_W-1:0] = req_data[RES_W-1:0];
        plen = CNT_W'(RES_W);
        dir  = 1'b1;
      end
      3'd4: begin
        pl[REG_W+DATA_W-1:0] = {req_data, req_reg};
        plen = CNT_W'(REG_W + DATA_W);
        dir  = 1'b1;
      end
      default: begin
        pl[ADDR_W+CMD_W-1:0] = {req_cmd, req_addr};
        plen = CNT_W'(ADDR_W + CMD_W);
      end
    endcase
    par = '0;
    for (int j = 0; j < MAXP; j++)
      if (j < int'(plen)) par[j % PAR_N] = par[j % PAR_N] ^ pl[j];
    fr = FR_W'({dir, 1'b0}) | (FR_W'(pl) << 2) | (FR_W'(par) << (plen + CNT_W'(2)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sh   <= '0;
      left <= '0;
      k    <= 4'd8;
      hcnt <= '0;
      half <= 1'b0;
      gcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          sh   <= fr;
          left <= plen + CNT_W'(PAR_N + 2);
          k    <= kdiv;
          hcnt <= '0;
          half <= 1'b0;
          st   <= S_SEND;
        end
        S_SEND: begin
          if (hcnt == k - 4'd1) begin
            hcnt <= '0;
            if (!half) half <= 1'b1;
            else begin
              half <= 1'b0;
              sh   <= sh >> 1;
              left <= left - CNT_W'(1);
              if (left == CNT_W'(1)) begin
                st   <= S_GAP;
                gcnt <= '0;
              end
            end
          end else hcnt <= hcnt + 4'd1;
        end
        default: begin
          if (gcnt == {k, 2'b00} - 6'd1) st <= S_IDLE;
          else gcnt <= gcnt + 6'd1;
        end
      endcase
    end
  end

  // R1
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_out);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !req_ready));

  // R6
  mid_bit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && half && hcnt == 4'd0) |-> (line_out != $past(line_out)));

  // R7
  half_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND) |-> (hcnt < k));

  // R8
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(line_out));
endmodule

// File: tb/manch_tx_bench.sv
module manch_tx_bench;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [2:0] req_kind = 0;
  logic [9:0] req_addr = 0;
  logic [2:0] req_cmd = 0;
  logic [4:0] req_reg = 0;
  logic [15:0] req_data = 0;
  logic [1:0] rate_code = 0;
  logic req_ready, line_out, busy;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit ebits [64];
  int elen;

  always #5 clk = ~clk;

  manch_tx u_manch_tx (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int v, int w);
    for (int i = 0; i < w; i++) begin
      ebits[elen] = v[i];
      elen++;
    end
  endtask

  task automatic build(int kind, int a, int c, int r, int d);
    int pstart;
    bit p [10];
    elen = 0;
    push(0, 1);
    push((kind == 3 || kind == 4) ? 1 : 0, 1);
    pstart = elen;
    case (kind)
      1: begin push(a, 10); push(c, 3); push(r, 5); push(d, 16); end
      2: begin push(a, 10); push(c, 3); push(r, 5); end
      3: push(d, 11);
      4: begin push(r, 5); push(d, 16); end
      default: begin push(a, 10); push(c, 3); end
    endcase
    for (int i = 0; i < 10; i++) p[i] = 0;
    for (int j = 0; j < elen - pstart; j++) p[j % 10] ^= ebits[pstart + j];
    for (int i = 0; i < 10; i++) begin
      ebits[elen] = p[i];
      elen++;
    end
  endtask

  function automatic int divof(int rc);
    return (rc == 0) ? 8 : (rc == 1) ? 4 : (rc == 2) ? 2 : 1;
  endfunction

  task automatic send(int kind, int a, int c, int r, int d, int rc, bit noise, string tag);
    int kk, errs, busyerr;
    build(kind, a, c, r, d);
    kk = divof(rc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_kind = 3'(kind); req_addr = 10'(a); req_cmd = 3'(c);
    req_reg = 5'(r); req_data = 16'(d); rate_code = 2'(rc);
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(busy && !req_ready, "R2 busy after accept", busy, 1);
    errs = 0;
    busyerr = 0;
    for (int t = 0; t < 2 * kk * elen; t++) begin
      if (line_out !== (ebits[t / (2 * kk)] ^ ((t / kk) % 2 == 1))) errs++;
      if (busy !== 1'b1) busyerr++;
      if (noise) begin
        req_valid = 1'($urandom);
        req_kind = 3'($urandom); req_addr = 10'($urandom); req_cmd = 3'($urandom);
        req_reg = 5'($urandom); req_data = 16'($urandom); rate_code = 2'($urandom);
      end
      @(negedge clk);
    end
    req_valid = 0;
    chk(errs == 0 && busyerr == 0,
        {tag, noise ? " R2 R3 R4 R5 R6 R7 frame under noise" : " R3 R4 R5 R6 R7 frame"},
        errs + busyerr, 0);
    errs = 0;
    for (int g = 0; g < 4 * kk; g++) begin
      if (line_out !== 1'b0 || busy !== 1'b1 || req_ready !== 1'b0) errs++;
      @(negedge clk);
    end
    chk(errs == 0, "R8 idle gap", errs, 0);
    chk(!busy && req_ready, "R8 ready after gap", req_ready, 1);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!line_out && !busy && req_ready, "R1 reset state", {line_out, busy, req_ready}, 1);
    send(0, 10'h3ff, 7, 0, 0, 3, 0, "R3 normal all ones");
    send(1, 10'h155, 5, 5'h1f, 16'hffff, 2, 0, "R3 write");
    send(1, 0, 0, 0, 0, 0, 0, "R5 write zeros");
    send(2, 10'h001, 1, 5'h10, 0, 1, 0, "R4 read lsb first");
    send(3, 0, 0, 0, 16'hf7ff, 3, 0, "R3 result upper data ignored");
    send(4, 0, 0, 5'h0a, 16'h8001, 0, 0, "R3 readout");
    send(5, 10'h2aa, 2, 3, 4, 3, 0, "R9 kind 5");
    send(7, 10'h0f0, 6, 3, 4, 2, 0, "R9 kind 7");
    send(1, 10'h3c3, 3, 5'h15, 16'h5a5a, 1, 1, "R2 noise");
    for (int i = 0; i < 30; i++)
      send(int'($urandom % 8), int'($urandom % 1024), int'($urandom % 8),
           int'($urandom % 32), int'($urandom % 65536), int'($urandom % 4),
           1'($urandom), "R7 random");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule